// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address of every data beat in an SDRAM read or write burst. Upstream logic supplies the programmed length code and wrap-order bit from the mode register. It then pulses a start request that carries the first column. From the next clock on, the block delivers one column per cycle with a valid strobe. The final beat of a fixed-length burst also carries a last flag.

Two wrap orders are offered. In the linear order, the low address bits count upward and wrap inside the aligned block of the burst size. In the interleaved order, the low bits are the starting low bits XORed with the beat number. A page-length code runs a linear walk across the whole 512-column row, rolling from 511 back to 0, until a stop or a new start ends it. Length codes that the mode register does not define, and the page length combined with the interleaved order, are flagged as illegal. A start request under such a mode has no effect.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `beat_vld` and `beat_last` are 0.
- R2: Length code `len_code` 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `beat_last` is 1 only together with the valid strobe of the final beat, and `beat_vld` is 0 in the cycle after the final beat unless a new burst was accepted.
- R3: With `wrap_intl`=0, beat i (starting at 0) of a burst of length L from column S has column (S with its low log2(L) bits cleared) + ((S mod L) + i) mod L. The upper column bits never change within the burst.
- R4: With `wrap_intl`=1, beat i has its low log2(L) bits equal to (S mod L) XOR i, and its upper bits equal to those of S.
- R5: Length code 3'b111 with `wrap_intl`=0 gives a page burst. Beat i has column (S+i) mod 512, the burst runs without limit, and `beat_last` stays 0.
- R6: `mode_err` is 1 exactly when `len_code` is 3'b100, 3'b101 or 3'b110, or when it is 3'b111 with `wrap_intl`=1. A `start` sampled while `mode_err` is 1 is ignored: an idle block stays idle, and a running burst continues unchanged.
- R7: `stop` sampled during a beat, without an accepted start, makes `beat_vld` 0 in the next cycle.
- R8: An accepted start during a running burst abandons that burst. The next cycle shows beat 0 of the new burst.
- R9: The first beat appears in the cycle after `start` is sampled, carrying `start_col`. Later beats follow one per clock.
- R10: Length and wrap order are captured when the burst is accepted. Changing `len_code` or `wrap_intl` during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| len_code | input | 3 | Burst length code from the mode register |
| wrap_intl | input | 1 | Wrap order: 0 linear, 1 interleaved |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | End the running burst |
| col | output | 9 | Column of the current beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err | output | 1 | Current length/order combination is illegal |

## Verification
The bench sweeps every legal length in both orders from every low-bit start position, at several upper-bit settings. This exposes a wrap that crosses the aligned block or carries into the upper bits, and an interleave computed as an addition. A page burst is started near the top of the row and run past 511. A design that saturates, stops at the row end, or raises the last flag would fail there. The remaining cases cover the following faults: an illegal-mode start issued while idle and while busy (a design that half-accepts it would truncate or restart the burst); a mid-burst restart and a mid-burst stop (stale beats would appear); and mode inputs changed during a burst (a design that does not capture the mode would change its length or order midway).

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int COL_W = 9;
    localparam int LG_W  = 2;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    // Captured burst shape
    typedef struct packed {
        logic            page;  // run across whole row until ended
        logic            intl;  // interleaved wrap order
        logic [LG_W-1:0] lg;    // log2 of fixed burst length
    } burst_mode_t;

    // Bits of the column that move during a burst
    function automatic logic [COL_W-1:0] span_mask(burst_mode_t m);
        logic [COL_W-1:0] mk;
        if (m.page) mk = '1;
        else        mk = COL_W'((1 << m.lg) - 1);
        return mk;
    endfunction

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
    import burst_seq_pkg::*;
(
    input  logic [2:0]  len_code,
    input  logic        wrap_intl,
    output burst_mode_t mode,
    output logic        err
);

    always_comb begin
        mode      = '0;
        mode.intl = wrap_intl;
        err       = 1'b0;
        case (len_code)
            LEN_1:    mode.lg = 2'd0;
            LEN_2:    mode.lg = 2'd1;
            LEN_4:    mode.lg = 2'd2;
            LEN_8:    mode.lg = 2'd3;
            LEN_PAGE: begin
                mode.page = 1'b1;
                err       = wrap_intl;   // page length needs linear order
            end
            default:  err = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
    import burst_seq_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] idx,
    input  burst_mode_t   mode,
    output logic [CW-1:0] col
);

    logic [CW-1:0] mask;
    logic [CW-1:0] moving;

    always_comb begin
        mask = CW'(span_mask(mode));
        if (mode.intl) moving = (base ^ idx) & mask;
        else           moving = (base + idx) & mask;
        col = (base & ~mask) | moving;
    end

endmodule

// File: rtl/burst_track.sv
module burst_track
    import burst_seq_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic          stop,
    input  burst_mode_t   mode_in,
    input  logic          mode_err,
    output logic          active,
    output logic [CW-1:0] base,
    output logic [CW-1:0] idx,
    output burst_mode_t   mode_q,
    output logic          last
);

    logic          go;
    logic [CW-1:0] final_idx;

    assign go        = start && !mode_err;
    assign final_idx = CW'((1 << mode_q.lg) - 1);
    assign last      = active && !mode_q.page && (idx == final_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            idx    <= '0;
            mode_q <= '0;
        end else if (go) begin
            active <= 1'b1;
            base   <= start_col;
            idx    <= '0;
            mode_q <= mode_in;
        end else if (active) begin
            if (stop || last) active <= 1'b0;
            else              idx    <= idx + 1'b1;
        end
    end

    // R7
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (active && stop && !go) |=> !active);

    // R6
    bad_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && start && mode_err) |=> !active);

    // R2
    last_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !go) |=> !active);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    len_code,
    input  logic          wrap_intl,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic          stop,
    output logic [CW-1:0] col,
    output logic          beat_vld,
    output logic          beat_last,
    output logic          mode_err
);

    burst_mode_t   dec_mode;
    burst_mode_t   run_mode;
    logic          run_active;
    logic          run_last;
    logic [CW-1:0] run_base;
    logic [CW-1:0] run_idx;

    burst_mode_dec u_dec (
        .len_code  (len_code),
        .wrap_intl (wrap_intl),
        .mode      (dec_mode),
        .err       (mode_err)
    );

    burst_track #(.CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .stop      (stop),
        .mode_in   (dec_mode),
        .mode_err  (mode_err),
        .active    (run_active),
        .base      (run_base),
        .idx       (run_idx),
        .mode_q    (run_mode),
        .last      (run_last)
    );

    burst_col_calc #(.CW(CW)) u_calc (
        .base (run_base),
        .idx  (run_idx),
        .mode (run_mode),
        .col  (col)
    );

    assign beat_vld  = run_active;
    assign beat_last = run_last;

    // R2
    last_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_vld);

    // R9
    first_beat_col_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !mode_err) |=> (beat_vld && col == $past(start_col)));

    // R3
    upper_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(beat_vld) && beat_vld && !$past(start && !mode_err))
        |-> (((col ^ $past(col)) & ~CW'(span_mask(run_mode))) == '0));

endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] len_code = 3'b000;
    logic       wrap_intl = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic       stop = 1'b0;
    logic [8:0] col;
    logic       beat_vld;
    logic       beat_last;
    logic       mode_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst(rst), .len_code(len_code), .wrap_intl(wrap_intl),
        .start(start), .start_col(start_col), .stop(stop),
        .col(col), .beat_vld(beat_vld), .beat_last(beat_last), .mode_err(mode_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int exp_col(int base, int i, int lg, bit intl, bit page);
        int blk, hi, lo;
        if (page) return (base + i) % 512;
        blk = 1 << lg;
        hi  = (base / blk) * blk;
        lo  = base % blk;
        if (intl) return hi + (lo ^ i);
        return hi + ((lo + i) % blk);
    endfunction

    // Issue one burst and follow it to the end
    task automatic run_burst(input int lg, input bit intl, input int base);
        int n = 1 << lg;
        @(negedge clk);
        len_code = 3'(lg); wrap_intl = intl; start = 1'b1; start_col = 9'(base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk(intl ? "R4 vld" : "R3 vld", int'(beat_vld), 1);
            chk(intl ? "R4 col" : "R3 col", int'(col), exp_col(base, i, lg, intl, 0));
            chk("R2 last", int'(beat_last), (i == n - 1) ? 1 : 0);
        end
        @(negedge clk);
        chk("R2 end", int'(beat_vld), 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 vld", int'(beat_vld), 0);
        chk("R1 last", int'(beat_last), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld after", int'(beat_vld), 0);

        // R6 error decode over every code and order
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 2; t++) begin
                len_code = 3'(c); wrap_intl = t[0];
                #0.1;
                chk("R6 err", int'(mode_err),
                    ((c >= 4 && c <= 6) || (c == 7 && t == 1)) ? 1 : 0);
            end
        end

        // R2 R3 R4 R9 sweep
        for (int lg = 0; lg < 4; lg++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s < 16; s++) begin
                    run_burst(lg, t[0], s);
                    run_burst(lg, t[0], 496 + s);
                    run_burst(lg, t[0], 160 + s);
                end

        // R5 page burst across the row end, then R7 stop
        @(negedge clk);
        len_code = 3'b111; wrap_intl = 1'b0; start = 1'b1; start_col = 9'd505;
        for (int i = 0; i < 520; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R5 vld", int'(beat_vld), 1);
            chk("R5 col", int'(col), (505 + i) % 512);
            chk("R5 last", int'(beat_last), 0);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R7 page stop", int'(beat_vld), 0);

        // R6 illegal start while idle
        for (int c = 4; c < 8; c++) begin
            @(negedge clk);
            len_code = 3'(c); wrap_intl = 1'b1; start = 1'b1; start_col = 9'd7;
            @(negedge clk);
            start = 1'b0;
            chk("R6 idle ignore", int'(beat_vld), 0);
        end

        // R6 illegal start while busy, R10 mode change mid-burst
        @(negedge clk);
        len_code = 3'b011; wrap_intl = 1'b0; start = 1'b1; start_col = 9'd10;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R6 busy col", int'(col), exp_col(10, i, 3, 0, 0));
            chk("R10 last", int'(beat_last), (i == 7) ? 1 : 0);
            if (i == 1) begin len_code = 3'b000; wrap_intl = 1'b1; end
            if (i == 3) begin len_code = 3'b101; start = 1'b1; start_col = 9'd200; end
            if (i == 4) begin len_code = 3'b010; end
        end
        @(negedge clk);
        chk("R10 end", int'(beat_vld), 0);

        // R8 restart mid-burst
        @(negedge clk);
        len_code = 3'b011; wrap_intl = 1'b0; start = 1'b1; start_col = 9'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R8 first col", int'(col), exp_col(3, i, 3, 0, 0));
        end
        len_code = 3'b010; wrap_intl = 1'b1; start = 1'b1; start_col = 9'd41;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R8 new col", int'(col), exp_col(41, i, 2, 1, 0));
            chk("R8 last", int'(beat_last), (i == 3) ? 1 : 0);
        end
        @(negedge clk);
        chk("R8 end", int'(beat_vld), 0);

        // R7 stop a fixed burst
        @(negedge clk);
        len_code = 3'b011; wrap_intl = 1'b1; start = 1'b1; start_col = 9'd77;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R7 col", int'(col), exp_col(77, i, 3, 1, 0));
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R7 stop", int'(beat_vld), 0);

        done = 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            done = 1;
        end
    end

    initial begin
        wait (done);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule